// File: doc/BRIEF.md
# Dual-Priority Conversion Request Scheduler

This block chooses what a conversion filter does next. Two classes of work compete for the filter. The high-priority class is an injected sequence of one or more conversions that run back to back. The low-priority class is a regular conversion, which runs once or repeats continuously. Software raises a one-cycle start pulse for either class. The datapath returns a one-cycle done pulse when each conversion ends. The scheduler answers with a start strobe, a kind bit that tells the datapath which class it is starting, and the injected channel index.

An injected request never cuts a regular conversion short. It waits for the next conversion boundary and then takes over. A regular request that arrives while an injected sequence runs is held until the sequence ends. A continuous regular stream that an injected sequence suspended resumes on its own. The first regular result after either kind of deferral carries a late marker. When neither class is active, the idle output asserts so that the filter and integrator can be clock-gated.

Top module: `conv_sched`

## Requirements
- R1: After reset no conversion is running, start_o is low, both busy outputs are low and filt_idle_o is high.
- R2: From idle, a regular start gives a start strobe on the next cycle with start_inj_o = 0 (0 means regular, 1 means injected). With continuous mode off, the block returns to idle after that conversion's done pulse.
- R3: With cont_en_i high, a new regular start strobe follows every regular done pulse on the next cycle. If cont_en_i is cleared during a conversion, that conversion finishes and no further regular conversion starts.
- R4: An injected sequence runs L conversions, where L is the length sampled when the sequence starts. A length of 0 counts as 1, and a length above MAX_INJ is clamped to MAX_INJ. inj_idx_o counts 0 to L-1 on the strobes. The next strobe follows each non-final done pulse on the next cycle, and inj_busy_o stays high from the first strobe until the last done pulse.
- R5: An injected request made during a regular conversion does not abort it. The injected strobe appears on the cycle after that conversion's done pulse, and no strobe appears while a conversion is running without a done pulse.
- R6: A regular start made during an injected sequence is held. Its strobe appears on the cycle after the sequence's final done pulse.
- R7: A continuous regular stream suspended by an injected sequence resumes after the sequence if cont_en_i is still high, and does not resume if cont_en_i was cleared.
- R8: reg_late_o is high with the done pulse of the first regular conversion that starts straight after an injected sequence, and low with every other regular done pulse.
- R9: At the end of an injected sequence the next action is chosen by precedence: a held or resuming regular request first, then a held injected request, then idle.
- R10: Several starts of the same kind that arrive while that kind is already waiting merge into one conversion or one sequence.
- R11: filt_idle_o is high exactly when neither reg_busy_o nor inj_busy_o is high, and no start strobe occurs while it is high.
- R12: If both starts arrive in the same cycle while idle, the injected sequence runs first and the regular conversion follows, marked late.
- R13: Done pulses that arrive while idle have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_start_i | input | 1 | Regular start request pulse |
| inj_start_i | input | 1 | Injected start request pulse |
| cont_en_i | input | 1 | Continuous regular mode enable |
| conv_done_i | input | 1 | Datapath done pulse for the current conversion |
| inj_len_i | input | LEN_W | Injected sequence length |
| start_o | output | 1 | One-cycle start strobe to the datapath |
| start_inj_o | output | 1 | Kind of the strobed conversion (1 injected, 0 regular) |
| inj_idx_o | output | IDX_W | Position within the injected sequence |
| reg_busy_o | output | 1 | Regular conversion in progress |
| inj_busy_o | output | 1 | Injected sequence in progress |
| reg_late_o | output | 1 | Late marker on a deferred regular result |
| filt_idle_o | output | 1 | Filter and integrator may idle |

## Verification
The bench builds the block with MAX_INJ = 4. A programmed length of 7 therefore exercises the clamp, and a length of 0 exercises the floor, both with short runs. Its datapath model answers each strobe after three cycles. That leaves a window of several cycles inside every conversion, so the bench can land extra requests there, issue same-cycle double requests, change the length during a sequence and drop continuous mode at a known point.

// File: rtl/conv_sched_pkg.sv
package conv_sched_pkg;

    typedef enum logic [1:0] {
        SCH_IDLE = 2'd0,
        SCH_REG  = 2'd1,
        SCH_INJ  = 2'd2
    } sch_state_e;

    typedef enum logic {
        KIND_REG = 1'b0,
        KIND_INJ = 1'b1
    } conv_kind_e;

    localparam int unsigned NUM_KINDS = 2;
    localparam int unsigned KI_REG    = 0;
    localparam int unsigned KI_INJ    = 1;

    // Effective sequence length: zero counts as one, large values saturate.
    function automatic int unsigned clamp_len(input int unsigned req, input int unsigned cap);
        if (req == 0)  return 1;
        if (req > cap) return cap;
        return req;
    endfunction

endpackage

// File: rtl/cs_req_hold.sv
module cs_req_hold
    import conv_sched_pkg::*;
#(
    parameter int unsigned N = NUM_KINDS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] take_i,
    output logic [N-1:0] pend_o
);

    for (genvar k = 0; k < N; k++) begin : g_kind
        logic held_q;
        always_ff @(posedge clk) begin
            if (rst)
                held_q <= 1'b0;
            else if (take_i[k])
                held_q <= 1'b0;
            else if (set_i[k])
                held_q <= 1'b1;
        end
        assign pend_o[k] = held_q;

        // repeated requests only keep the single flag set
        assert_merge_keeps_R10: assert property (@(posedge clk) disable iff (rst)
            (held_q && !take_i[k]) |=> held_q);
    end

endmodule

// File: rtl/cs_inj_seq.sv
module cs_inj_seq
    import conv_sched_pkg::*;
#(
    parameter int unsigned MAX_INJ = 8,
    parameter int unsigned LEN_W   = 4,
    parameter int unsigned IDX_W   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             step_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             last_o
);

    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] top_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            top_q <= '0;
        end else if (load_i) begin
            idx_q <= '0;
            top_q <= IDX_W'(clamp_len(int'(len_i), MAX_INJ) - 1);
        end else if (step_i) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign idx_o  = idx_q;
    assign last_o = (idx_q == top_q);

    assert_idx_bound_R4: assert property (@(posedge clk) disable iff (rst)
        idx_q <= top_q);

    assert_step_not_last_R4: assert property (@(posedge clk) disable iff (rst)
        step_i |-> !last_o);

endmodule

// File: rtl/cs_arbiter.sv
module cs_arbiter
    import conv_sched_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_start_i,
    input  logic       inj_start_i,
    input  logic       cont_en_i,
    input  logic       done_i,
    input  logic       reg_pend_i,
    input  logic       inj_pend_i,
    input  logic       seq_last_i,
    output sch_state_e state_o,
    output logic       take_reg_o,
    output logic       take_inj_o,
    output logic       seq_load_o,
    output logic       seq_step_o,
    output logic       start_o,
    output conv_kind_e kind_o,
    output logic       reg_late_o
);

    sch_state_e st_q, st_d;
    logic       late_q, late_d;
    logic       hold_q, hold_d;
    logic       start_q;
    conv_kind_e kind_q;
    logic       reg_req, inj_req, resume_ok;
    logic       launch_r, launch_i, step;

    always_comb begin
        reg_req   = reg_start_i | reg_pend_i;
        inj_req   = inj_start_i | inj_pend_i;
        resume_ok = reg_req | (hold_q & cont_en_i);
        st_d      = st_q;
        late_d    = late_q;
        hold_d    = hold_q;
        launch_r  = 1'b0;
        launch_i  = 1'b0;
        step      = 1'b0;
        unique case (st_q)
            SCH_IDLE: begin
                if (inj_req) begin
                    st_d     = SCH_INJ;
                    launch_i = 1'b1;
                end else if (reg_req) begin
                    st_d     = SCH_REG;
                    launch_r = 1'b1;
                    late_d   = 1'b0;
                end
            end
            SCH_REG: begin
                if (done_i) begin
                    late_d = 1'b0;
                    if (inj_req) begin
                        st_d     = SCH_INJ;
                        launch_i = 1'b1;
                        hold_d   = cont_en_i;
                    end else if (reg_req || cont_en_i) begin
                        launch_r = 1'b1;
                    end else begin
                        st_d = SCH_IDLE;
                    end
                end
            end
            SCH_INJ: begin
                if (done_i) begin
                    if (!seq_last_i) begin
                        step = 1'b1;
                    end else begin
                        hold_d = 1'b0;
                        if (resume_ok) begin
                            st_d     = SCH_REG;
                            launch_r = 1'b1;
                            late_d   = 1'b1;
                        end else if (inj_req) begin
                            launch_i = 1'b1;
                        end else begin
                            st_d = SCH_IDLE;
                        end
                    end
                end
            end
            default: st_d = SCH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= SCH_IDLE;
            late_q  <= 1'b0;
            hold_q  <= 1'b0;
            start_q <= 1'b0;
            kind_q  <= KIND_REG;
        end else begin
            st_q    <= st_d;
            late_q  <= late_d;
            hold_q  <= hold_d;
            start_q <= launch_r | launch_i | step;
            kind_q  <= (launch_i || step) ? KIND_INJ : KIND_REG;
        end
    end

    assign state_o    = st_q;
    assign take_reg_o = launch_r;
    assign take_inj_o = launch_i;
    assign seq_load_o = launch_i;
    assign seq_step_o = step;
    assign start_o    = start_q;
    assign kind_o     = kind_q;
    assign reg_late_o = (st_q == SCH_REG) && done_i && late_q;

    assert_no_abort_R5: assert property (@(posedge clk) disable iff (rst)
        (st_q == SCH_REG && !done_i) |=> !start_q);

    assert_reg_held_R6: assert property (@(posedge clk) disable iff (rst)
        (st_q == SCH_INJ && !(done_i && seq_last_i)) |=> !(start_q && kind_q == KIND_REG));

    assert_cont_restart_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q == SCH_REG && done_i && cont_en_i && !inj_start_i && !inj_pend_i)
        |=> (start_q && kind_q == KIND_REG));

    assert_held_reg_first_R9: assert property (@(posedge clk) disable iff (rst)
        (st_q == SCH_INJ && done_i && seq_last_i && reg_pend_i)
        |=> (st_q == SCH_REG && late_q));

    assert_late_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (st_q == SCH_REG && done_i) |=> !late_q);

    assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (rst)
        (st_q == SCH_IDLE && !reg_start_i && !inj_start_i && !reg_pend_i && !inj_pend_i)
        |=> (st_q == SCH_IDLE && !start_q));

    assert_same_cycle_R12: assert property (@(posedge clk) disable iff (rst)
        (st_q == SCH_IDLE && reg_start_i && inj_start_i)
        |=> (kind_q == KIND_INJ && reg_pend_i));

endmodule

// File: rtl/conv_sched.sv
module conv_sched
    import conv_sched_pkg::*;
#(
    parameter  int unsigned MAX_INJ = 8,
    localparam int unsigned LEN_W   = $clog2(MAX_INJ + 1),
    localparam int unsigned IDX_W   = (MAX_INJ > 1) ? $clog2(MAX_INJ) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_start_i,
    input  logic             inj_start_i,
    input  logic             cont_en_i,
    input  logic             conv_done_i,
    input  logic [LEN_W-1:0] inj_len_i,
    output logic             start_o,
    output logic             start_inj_o,
    output logic [IDX_W-1:0] inj_idx_o,
    output logic             reg_busy_o,
    output logic             inj_busy_o,
    output logic             reg_late_o,
    output logic             filt_idle_o
);

    logic [NUM_KINDS-1:0] req_set, req_take, req_pend;
    logic                 take_reg, take_inj, seq_load, seq_step, seq_last;
    sch_state_e           state;
    conv_kind_e           kind;

    assign req_set[KI_REG]  = reg_start_i;
    assign req_set[KI_INJ]  = inj_start_i;
    assign req_take[KI_REG] = take_reg;
    assign req_take[KI_INJ] = take_inj;

    cs_req_hold #(.N(NUM_KINDS)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .set_i  (req_set),
        .take_i (req_take),
        .pend_o (req_pend)
    );

    cs_inj_seq #(.MAX_INJ(MAX_INJ), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .load_i (seq_load),
        .len_i  (inj_len_i),
        .step_i (seq_step),
        .idx_o  (inj_idx_o),
        .last_o (seq_last)
    );

    cs_arbiter u_arb (
        .clk         (clk),
        .rst         (rst),
        .reg_start_i (reg_start_i),
        .inj_start_i (inj_start_i),
        .cont_en_i   (cont_en_i),
        .done_i      (conv_done_i),
        .reg_pend_i  (req_pend[KI_REG]),
        .inj_pend_i  (req_pend[KI_INJ]),
        .seq_last_i  (seq_last),
        .state_o     (state),
        .take_reg_o  (take_reg),
        .take_inj_o  (take_inj),
        .seq_load_o  (seq_load),
        .seq_step_o  (seq_step),
        .start_o     (start_o),
        .kind_o      (kind),
        .reg_late_o  (reg_late_o)
    );

    assign start_inj_o = (kind == KIND_INJ);
    assign reg_busy_o  = (state == SCH_REG);
    assign inj_busy_o  = (state == SCH_INJ);
    assign filt_idle_o = (state == SCH_IDLE);

    assert_gate_no_start_R11: assert property (@(posedge clk) disable iff (rst)
        filt_idle_o |-> !start_o);

endmodule

// File: tb/sim_conv_sched.sv
module sim_conv_sched;

    localparam int unsigned MAXN = 4;
    localparam int unsigned LW   = $clog2(MAXN + 1);
    localparam int unsigned IW   = $clog2(MAXN);
    localparam int          LAT  = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          reg_start = 1'b0, inj_start = 1'b0, cont_en = 1'b0;
    logic          dp_done = 1'b0, spur = 1'b0;
    logic [LW-1:0] len = '0;
    logic          conv_done;
    logic          start_o, start_inj, reg_busy, inj_busy, reg_late, filt_idle;
    logic [IW-1:0] inj_idx;

    assign conv_done = dp_done | spur;

    conv_sched #(.MAX_INJ(MAXN)) u0 (
        .clk         (clk),
        .rst         (rst),
        .reg_start_i (reg_start),
        .inj_start_i (inj_start),
        .cont_en_i   (cont_en),
        .conv_done_i (conv_done),
        .inj_len_i   (len),
        .start_o     (start_o),
        .start_inj_o (start_inj),
        .inj_idx_o   (inj_idx),
        .reg_busy_o  (reg_busy),
        .inj_busy_o  (inj_busy),
        .reg_late_o  (reg_late),
        .filt_idle_o (filt_idle)
    );

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    task automatic check(bit ok, string req, int act, int exp, string what);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // datapath model: done pulse LAT cycles after each strobe
    int dly = 0;
    always @(negedge clk) begin
        dp_done <= 1'b0;
        if (rst) dly <= 0;
        else if (start_o) dly <= LAT;
        else if (dly > 0) begin
            dly <= dly - 1;
            if (dly == 1) dp_done <= 1'b1;
        end
    end

    // scoreboard
    typedef struct {bit inj; int idx; bit late;} exp_t;
    exp_t expq[$];
    exp_t cur;
    int   reg_seen = 0, inj_seen = 0;
    bit   prev_busy = 0, prev_done = 0;

    task automatic push(bit inj, int idx, bit late);
        exp_t e;
        e.inj = inj; e.idx = idx; e.late = late;
        expq.push_back(e);
    endtask

    always begin
        @(negedge clk);
        #1;
        if (!rst) begin
            check(filt_idle == !(reg_busy | inj_busy), "R11", int'(filt_idle),
                  int'(!(reg_busy | inj_busy)), "idle gate");
            if (start_o) begin
                if (prev_busy)
                    check(prev_done, "R5", int'(prev_done), 1, "strobe while busy must follow a done");
                check(start_inj ? inj_busy : reg_busy, "R4", 0, 1, "busy matches started kind");
                if (expq.size() == 0) begin
                    check(0, "R10", int'(start_inj), -1, "unexpected start strobe");
                end else begin
                    cur = expq.pop_front();
                    check(start_inj == cur.inj, "R9", int'(start_inj), int'(cur.inj), "kind order");
                    if (cur.inj)
                        check(int'(inj_idx) == cur.idx, "R4", int'(inj_idx), cur.idx, "injected index");
                end
                if (start_inj) inj_seen++; else reg_seen++;
            end
            if (conv_done && reg_busy)
                check(reg_late == cur.late, "R8", int'(reg_late), int'(cur.late), "late marker");
            prev_busy = reg_busy | inj_busy;
            prev_done = conv_done;
        end else begin
            prev_busy = 0;
            prev_done = 0;
        end
    end

    task automatic pulse(bit r, bit i, int cycles);
        @(negedge clk);
        reg_start = r;
        inj_start = i;
        repeat (cycles) @(negedge clk);
        reg_start = 1'b0;
        inj_start = 1'b0;
    endtask

    task automatic wait_reg(int n);
        while (reg_seen < n) @(negedge clk);
    endtask

    task automatic wait_inj(int n);
        while (inj_seen < n) @(negedge clk);
    endtask

    task automatic settle(string req);
        int run = 0;
        while (run < 10) begin
            @(negedge clk);
            #1;
            if (filt_idle) run++; else run = 0;
        end
        check(expq.size() == 0, req, expq.size(), 0, "expected strobes missing");
        expq.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual 0 expected 1 (run did not end)");
        report();
    end

    initial begin
        int b;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check(!start_o, "R1", int'(start_o), 0, "start after reset");
        check(!reg_busy && !inj_busy, "R1", int'(reg_busy | inj_busy), 0, "busy after reset");
        check(filt_idle, "R1", int'(filt_idle), 1, "idle after reset");

        // R2 single regular conversion
        push(0, 0, 0);
        pulse(1, 0, 1);
        settle("R2");

        // R4 sequence of three, then zero length, then clamp
        len = 3;
        push(1, 0, 0); push(1, 1, 0); push(1, 2, 0);
        pulse(0, 1, 1);
        settle("R4");
        len = 0;
        push(1, 0, 0);
        pulse(0, 1, 1);
        settle("R4");
        len = 7;
        for (int k = 0; k < 4; k++) push(1, k, 0);
        pulse(0, 1, 1);
        settle("R4");

        // R4 length sampled at sequence start
        len = 2;
        push(1, 0, 0); push(1, 1, 0);
        b = inj_seen;
        pulse(0, 1, 1);
        wait_inj(b + 1);
        len = 4;
        settle("R4");

        // R5 injected request during a regular conversion
        len = 2;
        push(0, 0, 0); push(1, 0, 0); push(1, 1, 0);
        b = reg_seen;
        pulse(1, 0, 1);
        wait_reg(b + 1);
        pulse(0, 1, 1);
        settle("R5");

        // R6 regular request during an injected sequence
        len = 3;
        push(1, 0, 0); push(1, 1, 0); push(1, 2, 0); push(0, 0, 1);
        b = inj_seen;
        pulse(0, 1, 1);
        wait_inj(b + 1);
        pulse(1, 0, 1);
        settle("R6");

        // R3 continuous mode, stopped during the third conversion
        cont_en = 1;
        push(0, 0, 0); push(0, 0, 0); push(0, 0, 0);
        b = reg_seen;
        pulse(1, 0, 1);
        wait_reg(b + 3);
        cont_en = 0;
        settle("R3");

        // R7 continuous stream suspended and resumed
        cont_en = 1;
        len = 2;
        push(0, 0, 0); push(0, 0, 0);
        b = reg_seen;
        pulse(1, 0, 1);
        wait_reg(b + 2);
        push(1, 0, 0); push(1, 1, 0); push(0, 0, 1);
        pulse(0, 1, 1);
        wait_reg(b + 3);
        cont_en = 0;
        settle("R7");

        // R7 no resume once continuous mode is dropped
        cont_en = 1;
        len = 1;
        push(0, 0, 0);
        b = reg_seen;
        pulse(1, 0, 1);
        wait_reg(b + 1);
        push(1, 0, 0);
        b = inj_seen;
        pulse(0, 1, 1);
        wait_inj(b + 1);
        cont_en = 0;
        settle("R7");

        // R9 both kinds held during a sequence
        len = 2;
        push(1, 0, 0); push(1, 1, 0); push(0, 0, 1); push(1, 0, 0); push(1, 1, 0);
        b = inj_seen;
        pulse(0, 1, 1);
        wait_inj(b + 1);
        pulse(1, 1, 1);
        settle("R9");

        // R10 merged injected requests during a regular conversion
        len = 1;
        push(0, 0, 0); push(1, 0, 0);
        b = reg_seen;
        pulse(1, 0, 1);
        wait_reg(b + 1);
        pulse(0, 1, 2);
        settle("R10");

        // R10 merged regular requests during an injected sequence
        push(1, 0, 0); push(0, 0, 1);
        b = inj_seen;
        pulse(0, 1, 1);
        wait_inj(b + 1);
        pulse(1, 0, 2);
        settle("R10");

        // R12 both kinds in the same cycle from idle
        push(1, 0, 0); push(0, 0, 1);
        pulse(1, 1, 1);
        settle("R12");

        // R13 stray done while idle
        @(negedge clk);
        spur = 1'b1;
        @(negedge clk);
        spur = 1'b0;
        #1;
        check(!start_o && filt_idle, "R13", int'(start_o), 0, "stray done while idle");
        settle("R13");

        report();
    end

endmodule